// File: doc/BRIEF.md
# Float-versus-integer compare unit

This unit compares an 80-bit double-extended floating-point value, taken from the top of a register stack, with a signed integer source. The integer can be 16 or 32 bits wide. The integer is first converted exactly into the extended format. The two values are then ordered with an unordered compare, which also checks the encoding class of the floating-point operand.

The unit returns a condition code on C3, C2, C1 and C0, plus three flags: invalid, denormal and stack underflow. When the pop variant is selected, it also drives stack-pop control: a pulse that marks the top register empty, and the advanced top-of-stack pointer.

A compare starts with a one-cycle strobe. The registered result appears on the next cycle together with a one-cycle valid pulse. Operand layout: bit 79 is the sign, bits 78:64 hold a 15-bit exponent biased by 16383, bit 63 is an explicit integer bit, and bits 62:0 hold the fraction.

Top module: `xf_int_cmp_unit`

## Requirements
- R1: A strobe on `start_i` in cycle n produces exactly one `res_valid_o` pulse in cycle n+1, and `res_valid_o` is never high without a strobe in the cycle before.
- R2: The code {C3,C2,C0} is 000 when the operand is greater than the integer, 001 when it is less, 100 when equal and 111 when unordered. C1 is always 0 on a result.
- R3: With `int_wide_i`=1 all 32 bits of `int_src_i` are a signed integer. With `int_wide_i`=0 only bits 15:0 are used, as a signed 16-bit integer, and bits 31:16 have no effect on the result.
- R4: The integer is converted exactly, so integers at the 32-bit extremes compare equal to their exact extended values. A fractional part of half a unit above 2147483647 still compares greater.
- R5: A NaN operand gives code 111 and raises invalid. A NaN has exponent 0x7FFF, bit 63 set and a nonzero fraction. Infinities (exponent 0x7FFF, bit 63 set, fraction zero) compare as ordered values beyond every integer.
- R6: Three encodings are unsupported and give 111 with invalid: a nonzero exponent with bit 63 clear, a zero exponent with bit 63 set, and exponent 0x7FFF with bit 63 clear.
- R7: Positive and negative zero both compare equal to the integer 0.
- R8: A denormal operand (exponent 0, bit 63 clear, nonzero fraction) on a non-empty register raises the denormal flag and is still compared by value.
- R9: When `top_empty_i` is set, the result is 111 with underflow and invalid raised, the denormal flag clear, no pop pulse, and `top_ptr_o` equal to `top_ptr_i`.
- R10: In the pop variant with a non-empty top, `pop_o` pulses with the result and `top_ptr_o` is `top_ptr_i`+1 modulo 8; this also holds for a NaN operand. Without the pop variant `pop_o` stays 0 and `top_ptr_o` equals `top_ptr_i`.
- R11: While reset is held, and after it, `res_valid_o`, all flags and `pop_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Compare strobe |
| top_val_i | input | 80 | Top-of-stack extended operand |
| top_empty_i | input | 1 | Top register is tagged empty |
| int_src_i | input | 32 | Integer source |
| int_wide_i | input | 1 | 1: 32-bit source, 0: 16-bit source in bits 15:0 |
| pop_req_i | input | 1 | Pop variant select |
| top_ptr_i | input | 3 | Current top-of-stack pointer |
| res_valid_o | output | 1 | Result valid pulse |
| c3_o | output | 1 | Condition bit C3 |
| c2_o | output | 1 | Condition bit C2 |
| c1_o | output | 1 | Condition bit C1 (always 0) |
| c0_o | output | 1 | Condition bit C0 |
| inv_o | output | 1 | Invalid-operation flag |
| den_o | output | 1 | Denormal-operand flag |
| uflow_o | output | 1 | Stack-underflow flag |
| pop_o | output | 1 | Mark top empty, pointer advanced |
| top_ptr_o | output | 3 | Pointer after the operation |

## Verification
The bench builds the unit with its default parameters: a 32-bit wide integer path, a 16-bit narrow path and a 3-bit stack pointer. With these values the most negative and most positive integers of both widths can be driven directly. The ignored upper half of a narrow source can be made to disagree with the sign-extended low half. The pointer wrap from 7 to 0 is reachable in a single pop.

// File: rtl/xf_cmp_pkg.sv
package xf_cmp_pkg;

    localparam int EXP_W    = 15;
    localparam int MAN_W    = 64;
    localparam int FP_W     = 1 + EXP_W + MAN_W;
    localparam int EXP_BIAS = (1 << (EXP_W - 1)) - 1;
    localparam logic [EXP_W-1:0] EXP_ALL1 = '1;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] expo;
        logic [MAN_W-1:0] man;
    } xf_t;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_DENORM,
        CLS_NORMAL,
        CLS_INF,
        CLS_NAN,
        CLS_BAD
    } xf_cls_e;

    typedef enum logic [1:0] {
        REL_GT,
        REL_LT,
        REL_EQ,
        REL_UN
    } rel_e;

    typedef struct packed {
        logic c3;
        logic c2;
        logic c0;
    } cc_t;

    function automatic cc_t rel_to_cc(rel_e r);
        cc_t c;
        case (r)
            REL_GT:  c = '{c3: 1'b0, c2: 1'b0, c0: 1'b0};
            REL_LT:  c = '{c3: 1'b0, c2: 1'b0, c0: 1'b1};
            REL_EQ:  c = '{c3: 1'b1, c2: 1'b0, c0: 1'b0};
            default: c = '{c3: 1'b1, c2: 1'b1, c0: 1'b1};
        endcase
        return c;
    endfunction

    function automatic logic is_zero(xf_t v);
        return (v.expo == '0) && (v.man == '0);
    endfunction

endpackage

// File: rtl/xf_classify.sv
module xf_classify
    import xf_cmp_pkg::*;
(
    input  xf_t     op_i,
    output xf_cls_e cls_o
);
    logic int_bit;
    logic frac_nz;

    always_comb begin
        int_bit = op_i.man[MAN_W-1];
        frac_nz = (op_i.man[MAN_W-2:0] != '0);
        if (op_i.expo == '0) begin
            if (int_bit)      cls_o = CLS_BAD;
            else if (frac_nz) cls_o = CLS_DENORM;
            else              cls_o = CLS_ZERO;
        end else if (!int_bit) begin
            cls_o = CLS_BAD;
        end else if (op_i.expo == EXP_ALL1) begin
            cls_o = frac_nz ? CLS_NAN : CLS_INF;
        end else begin
            cls_o = CLS_NORMAL;
        end
    end
endmodule

// File: rtl/xf_int_to_ext.sv
module xf_int_to_ext
    import xf_cmp_pkg::*;
#(
    parameter int INT_W    = 32,
    parameter int NARROW_W = 16
) (
    input  logic [INT_W-1:0] src_i,
    input  logic             wide_i,
    output xf_t              val_o
);
    localparam int IDX_W = $clog2(INT_W);
    localparam int PAD_W = MAN_W - INT_W;

    logic [INT_W-1:0] sval;
    logic [INT_W-1:0] mag;
    logic [INT_W-1:0] norm;
    logic [IDX_W-1:0] msb;
    logic             neg;

    generate
        if (NARROW_W < INT_W) begin : g_ext
            always_comb begin
                sval = wide_i ? src_i
                              : {{(INT_W-NARROW_W){src_i[NARROW_W-1]}}, src_i[NARROW_W-1:0]};
            end
        end else begin : g_same
            always_comb sval = src_i;
        end
    endgenerate

    always_comb begin
        neg = sval[INT_W-1];
        mag = neg ? (~sval + 1'b1) : sval;
        msb = '0;
        for (int i = 0; i < INT_W; i++) begin
            if (mag[i]) msb = IDX_W'(i);
        end
        norm = mag << (INT_W - 1 - int'(msb));
        if (mag == '0) begin
            val_o = '0;
        end else begin
            val_o.sign = neg;
            val_o.expo = EXP_W'(EXP_BIAS) + EXP_W'(msb);
            val_o.man  = {norm, {PAD_W{1'b0}}};
        end
    end
endmodule

// File: rtl/xf_mag_order.sv
module xf_mag_order
    import xf_cmp_pkg::*;
(
    input  xf_t  a_i,
    input  xf_t  b_i,
    output rel_e rel_o
);
    logic a_z, b_z, sa, sb;
    logic [EXP_W+MAN_W-1:0] ka, kb;

    always_comb begin
        a_z = is_zero(a_i);
        b_z = is_zero(b_i);
        sa  = a_i.sign & ~a_z;
        sb  = b_i.sign & ~b_z;
        ka  = {a_i.expo, a_i.man};
        kb  = {b_i.expo, b_i.man};
        if (a_z && b_z)         rel_o = REL_EQ;
        else if (sa != sb)      rel_o = sa ? REL_LT : REL_GT;
        else if (ka == kb)      rel_o = REL_EQ;
        else if ((ka > kb) ^ sa) rel_o = REL_GT;
        else                    rel_o = REL_LT;
    end
endmodule

// File: rtl/xf_int_cmp_unit.sv
module xf_int_cmp_unit
    import xf_cmp_pkg::*;
#(
    parameter int INT_W    = 32,
    parameter int NARROW_W = 16,
    parameter int PTR_W    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [FP_W-1:0]  top_val_i,
    input  logic             top_empty_i,
    input  logic [INT_W-1:0] int_src_i,
    input  logic             int_wide_i,
    input  logic             pop_req_i,
    input  logic [PTR_W-1:0] top_ptr_i,
    output logic             res_valid_o,
    output logic             c3_o,
    output logic             c2_o,
    output logic             c1_o,
    output logic             c0_o,
    output logic             inv_o,
    output logic             den_o,
    output logic             uflow_o,
    output logic             pop_o,
    output logic [PTR_W-1:0] top_ptr_o
);
    xf_t     fp_op;
    xf_t     int_op;
    xf_cls_e fp_cls;
    rel_e    ord_rel;
    rel_e    fin_rel;
    cc_t     cc_n, cc_q;
    logic    unord_n, den_n, pop_n;
    logic [PTR_W-1:0] ptr_n;

    assign fp_op = xf_t'(top_val_i);

    xf_classify u_cls (
        .op_i  (fp_op),
        .cls_o (fp_cls)
    );

    xf_int_to_ext #(.INT_W(INT_W), .NARROW_W(NARROW_W)) u_cvt (
        .src_i  (int_src_i),
        .wide_i (int_wide_i),
        .val_o  (int_op)
    );

    xf_mag_order u_ord (
        .a_i   (fp_op),
        .b_i   (int_op),
        .rel_o (ord_rel)
    );

    always_comb begin
        unord_n = top_empty_i || (fp_cls == CLS_NAN) || (fp_cls == CLS_BAD);
        fin_rel = unord_n ? REL_UN : ord_rel;
        cc_n    = rel_to_cc(fin_rel);
        den_n   = !top_empty_i && (fp_cls == CLS_DENORM);
        pop_n   = pop_req_i && !top_empty_i;
        ptr_n   = pop_n ? top_ptr_i + 1'b1 : top_ptr_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid_o <= 1'b0;
            cc_q        <= '0;
            inv_o       <= 1'b0;
            den_o       <= 1'b0;
            uflow_o     <= 1'b0;
            pop_o       <= 1'b0;
            top_ptr_o   <= '0;
        end else begin
            res_valid_o <= start_i;
            pop_o       <= start_i && pop_n;
            if (start_i) begin
                cc_q      <= cc_n;
                inv_o     <= unord_n;
                den_o     <= den_n;
                uflow_o   <= top_empty_i;
                top_ptr_o <= ptr_n;
            end
        end
    end

    assign c3_o = cc_q.c3;
    assign c2_o = cc_q.c2;
    assign c0_o = cc_q.c0;
    assign c1_o = 1'b0;
endmodule

// File: rtl/xf_int_cmp_chk.sv
module xf_int_cmp_chk #(
    parameter int PTR_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             top_empty_i,
    input logic             pop_req_i,
    input logic [PTR_W-1:0] top_ptr_i,
    input logic             res_valid_o,
    input logic             c3_o,
    input logic             c2_o,
    input logic             c1_o,
    input logic             c0_o,
    input logic             inv_o,
    input logic             den_o,
    input logic             uflow_o,
    input logic             pop_o,
    input logic [PTR_W-1:0] top_ptr_o
);
    logic [2:0] code;
    assign code = {c3_o, c2_o, c0_o};

    a_r1_valid_follows_start: assert property (@(posedge clk) disable iff (rst)
        start_i |=> res_valid_o);

    a_r1_no_stray_valid: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> $past(start_i));

    a_r2_legal_code: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> ((code inside {3'b000, 3'b001, 3'b100, 3'b111}) && !c1_o));

    a_r5_invalid_iff_unordered: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> (inv_o == (code == 3'b111)));

    a_r9_underflow_no_pop: assert property (@(posedge clk) disable iff (rst)
        (res_valid_o && uflow_o) |-> (inv_o && !pop_o && !den_o));

    a_r10_pop_cause: assert property (@(posedge clk) disable iff (rst)
        pop_o |-> ($past(start_i) && $past(pop_req_i) && !$past(top_empty_i)));

    a_r10_pop_advances: assert property (@(posedge clk) disable iff (rst)
        pop_o |-> (top_ptr_o == PTR_W'($past(top_ptr_i) + 1'b1)));

    a_r10_hold_pointer: assert property (@(posedge clk) disable iff (rst)
        (res_valid_o && !pop_o) |-> (top_ptr_o == $past(top_ptr_i)));
endmodule

bind xf_int_cmp_unit xf_int_cmp_chk #(.PTR_W(PTR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .top_empty_i (top_empty_i),
    .pop_req_i   (pop_req_i),
    .top_ptr_i   (top_ptr_i),
    .res_valid_o (res_valid_o),
    .c3_o        (c3_o),
    .c2_o        (c2_o),
    .c1_o        (c1_o),
    .c0_o        (c0_o),
    .inv_o       (inv_o),
    .den_o       (den_o),
    .uflow_o     (uflow_o),
    .pop_o       (pop_o),
    .top_ptr_o   (top_ptr_o)
);

// File: tb/sim_xf_int_cmp_unit.sv
`timescale 1ns/1ps
module sim_xf_int_cmp_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [79:0] top_val_i = '0;
    logic        top_empty_i = 1'b0;
    logic [31:0] int_src_i = '0;
    logic        int_wide_i = 1'b1;
    logic        pop_req_i = 1'b0;
    logic [2:0]  top_ptr_i = '0;
    logic        res_valid_o, c3_o, c2_o, c1_o, c0_o, inv_o, den_o, uflow_o, pop_o;
    logic [2:0]  top_ptr_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [2:0] cc;
        logic       inv;
        logic       den;
        logic       uf;
        logic       pop;
        logic [2:0] ptr;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    xf_int_cmp_unit u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .top_val_i(top_val_i),
        .top_empty_i(top_empty_i), .int_src_i(int_src_i), .int_wide_i(int_wide_i),
        .pop_req_i(pop_req_i), .top_ptr_i(top_ptr_i), .res_valid_o(res_valid_o),
        .c3_o(c3_o), .c2_o(c2_o), .c1_o(c1_o), .c0_o(c0_o), .inv_o(inv_o),
        .den_o(den_o), .uflow_o(uflow_o), .pop_o(pop_o), .top_ptr_o(top_ptr_o)
    );

    function automatic logic [79:0] fx(logic s, logic [14:0] e, logic [63:0] m);
        return {s, e, m};
    endfunction

    task automatic run(input logic [79:0] v, input logic emp, input logic [31:0] src,
                       input logic wide, input logic pv, input logic [2:0] ptr,
                       input logic [2:0] cc, input logic inv, input logic den,
                       input logic uf, input logic pd, input logic [2:0] pn,
                       input string tag);
        exp_t e;
        e.cc = cc; e.inv = inv; e.den = den; e.uf = uf; e.pop = pd; e.ptr = pn; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        top_val_i = v; top_empty_i = emp; int_src_i = src; int_wide_i = wide;
        pop_req_i = pv; top_ptr_i = ptr; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    always @(negedge clk) begin
        if (!rst && res_valid_o) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R1 valid without a pending compare: got 1 expected 0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if ({c3_o, c2_o, c0_o} !== e.cc || c1_o !== 1'b0 || inv_o !== e.inv ||
                    den_o !== e.den || uflow_o !== e.uf || pop_o !== e.pop ||
                    top_ptr_o !== e.ptr) begin
                    fails++;
                    $display("FAIL %s: got cc=%b c1=%b inv=%b den=%b uf=%b pop=%b ptr=%0d expected cc=%b c1=0 inv=%b den=%b uf=%b pop=%b ptr=%0d",
                             e.tag, {c3_o, c2_o, c0_o}, c1_o, inv_o, den_o, uflow_o, pop_o,
                             top_ptr_o, e.cc, e.inv, e.den, e.uf, e.pop, e.ptr);
                end
            end
        end
    end

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
            $finish;
        end
    end

    localparam logic [63:0] ONE_M = 64'h8000_0000_0000_0000;
    localparam logic [14:0] B     = 15'd16383;

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        checks++;
        if ({res_valid_o, inv_o, den_o, uflow_o, pop_o} !== 5'b0) begin
            fails++;
            $display("FAIL R11 reset outputs: got %b expected 00000",
                     {res_valid_o, inv_o, den_o, uflow_o, pop_o});
        end
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        checks++;
        if ({res_valid_o, pop_o} !== 2'b0) begin
            fails++;
            $display("FAIL R11 idle after reset: got %b expected 00", {res_valid_o, pop_o});
        end

        // R2 basic orderings
        run(fx(0, B, ONE_M), 0, 32'd1, 1, 0, 3'd0, 3'b100, 0, 0, 0, 0, 3'd0, "R2 1.0 eq 1");
        // R1: pulse lasts one cycle
        @(negedge clk);
        checks++;
        if (res_valid_o !== 1'b0) begin
            fails++;
            $display("FAIL R1 valid width: got %b expected 0", res_valid_o);
        end
        run(fx(0, B, ONE_M), 0, 32'd2, 1, 0, 3'd6, 3'b001, 0, 0, 0, 0, 3'd6, "R2 1.0 lt 2");
        run(fx(0, B, ONE_M), 0, 32'd0, 1, 0, 3'd1, 3'b000, 0, 0, 0, 0, 3'd1, "R2 1.0 gt 0");
        run(fx(1, B, 64'hC000_0000_0000_0000), 0, 32'hFFFF_FFFF, 1, 0, 3'd0, 3'b001, 0, 0, 0, 0, 3'd0, "R2 -1.5 lt -1");
        run(fx(1, B, 64'hC000_0000_0000_0000), 0, 32'hFFFF_FFFE, 1, 0, 3'd0, 3'b000, 0, 0, 0, 0, 3'd0, "R2 -1.5 gt -2");

        // R7 signed zeros
        run(fx(0, 0, 0), 0, 32'd0, 1, 0, 3'd0, 3'b100, 0, 0, 0, 0, 3'd0, "R7 +0 eq 0");
        run(fx(1, 0, 0), 0, 32'd0, 1, 0, 3'd0, 3'b100, 0, 0, 0, 0, 3'd0, "R7 -0 eq 0");
        run(fx(1, 0, 0), 0, 32'd0, 0, 0, 3'd0, 3'b100, 0, 0, 0, 0, 3'd0, "R7 -0 eq narrow 0");
        run(fx(1, 0, 0), 0, 32'hFFFF_FFFF, 1, 0, 3'd0, 3'b000, 0, 0, 0, 0, 3'd0, "R7 -0 gt -1");

        // R4 exact conversion at 32-bit extremes
        run(fx(0, B + 15'd30, 64'hFFFF_FFFE_0000_0000), 0, 32'h7FFF_FFFF, 1, 0, 3'd0, 3'b100, 0, 0, 0, 0, 3'd0, "R4 max32 eq");
        run(fx(0, B + 15'd30, 64'hFFFF_FFFF_0000_0000), 0, 32'h7FFF_FFFF, 1, 0, 3'd0, 3'b000, 0, 0, 0, 0, 3'd0, "R4 max32+0.5 gt");
        run(fx(1, B + 15'd31, ONE_M), 0, 32'h8000_0000, 1, 0, 3'd0, 3'b100, 0, 0, 0, 0, 3'd0, "R4 min32 eq");
        run(fx(0, B + 15'd31, ONE_M), 0, 32'h7FFF_FFFF, 1, 0, 3'd0, 3'b000, 0, 0, 0, 0, 3'd0, "R4 2^31 gt max32");

        // R3 size select
        run(fx(1, B + 15'd15, ONE_M), 0, 32'hFFFF_8000, 0, 0, 3'd0, 3'b100, 0, 0, 0, 0, 3'd0, "R3 min16 eq");
        run(fx(1, B + 15'd15, ONE_M), 0, 32'h1234_8000, 0, 0, 3'd0, 3'b100, 0, 0, 0, 0, 3'd0, "R3 upper half ignored");
        run(fx(1, B + 15'd15, ONE_M), 0, 32'h1234_8000, 1, 0, 3'd0, 3'b001, 0, 0, 0, 0, 3'd0, "R3 same bits wide lt");
        run(fx(0, B + 15'd14, 64'hFFFE_0000_0000_0000), 0, 32'hABCD_7FFF, 0, 0, 3'd0, 3'b100, 0, 0, 0, 0, 3'd0, "R3 max16 eq");

        // R5 infinities and NaNs
        run(fx(0, 15'h7FFF, ONE_M), 0, 32'h7FFF_FFFF, 1, 0, 3'd0, 3'b000, 0, 0, 0, 0, 3'd0, "R5 +inf gt");
        run(fx(1, 15'h7FFF, ONE_M), 0, 32'h8000_0000, 1, 0, 3'd0, 3'b001, 0, 0, 0, 0, 3'd0, "R5 -inf lt");
        run(fx(0, 15'h7FFF, 64'hC000_0000_0000_0000), 0, 32'd0, 1, 0, 3'd0, 3'b111, 1, 0, 0, 0, 3'd0, "R5 quiet NaN");
        run(fx(1, 15'h7FFF, 64'h8000_0000_0000_0001), 0, 32'd5, 1, 1, 3'd4, 3'b111, 1, 0, 0, 1, 3'd5, "R5 R10 signalling NaN pops");

        // R6 unsupported encodings
        run(fx(0, B, 64'h4000_0000_0000_0000), 0, 32'd1, 1, 0, 3'd0, 3'b111, 1, 0, 0, 0, 3'd0, "R6 unnormal");
        run(fx(0, 0, ONE_M), 0, 32'd0, 1, 0, 3'd0, 3'b111, 1, 0, 0, 0, 3'd0, "R6 pseudo-denormal");
        run(fx(0, 15'h7FFF, 64'd0), 0, 32'd0, 1, 0, 3'd0, 3'b111, 1, 0, 0, 0, 3'd0, "R6 pseudo-infinity");
        run(fx(1, 15'h7FFF, 64'h4000_0000_0000_0000), 0, 32'd0, 1, 0, 3'd0, 3'b111, 1, 0, 0, 0, 3'd0, "R6 pseudo-NaN");

        // R8 denormals
        run(fx(0, 0, 64'd1), 0, 32'd0, 1, 0, 3'd0, 3'b000, 0, 1, 0, 0, 3'd0, "R8 +denormal gt 0");
        run(fx(1, 0, 64'd1), 0, 32'd0, 1, 0, 3'd0, 3'b001, 0, 1, 0, 0, 3'd0, "R8 -denormal lt 0");
        run(fx(0, 0, 64'h7FFF_FFFF_FFFF_FFFF), 0, 32'd1, 1, 0, 3'd0, 3'b001, 0, 1, 0, 0, 3'd0, "R8 denormal lt 1");

        // R9 empty top
        run(fx(0, 0, 64'd1), 1, 32'd0, 1, 1, 3'd5, 3'b111, 1, 0, 1, 0, 3'd5, "R9 empty no pop");

        // R10 pop variant
        run(fx(0, B, ONE_M), 0, 32'd1, 1, 1, 3'd7, 3'b100, 0, 0, 0, 1, 3'd0, "R10 pop wraps 7 to 0");
        run(fx(0, B, ONE_M), 0, 32'd3, 1, 1, 3'd2, 3'b001, 0, 0, 0, 1, 3'd3, "R10 pop 2 to 3");

        repeat (3) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R1 results missing: got %0d pending expected 0", sb.size());
        end
        done = 1'b1;
        report();
        $finish;
    end
endmodule